// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Unit

This block runs a free counter and keeps two capture channels next to it. Each channel watches one external capture pin. When a transition of a direction selected for that channel arrives, the channel copies the counter value into its own capture register. It can also raise a sticky interrupt flag. Software programs a small control word, clears the flags and reads the registers over a simple synchronous register bus. The read data comes back one clock after the address is presented.

The capture pins are asynchronous. Each pin passes through a two-stage synchroniser before its edge is detected, so the delay from a pin change to the capture is fixed. The interrupt output is high while either channel flag is set.

Top module: `cap_timer_top`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is low: control word, flags, counter, compare value and both capture registers.
- R2: When `count_en` is high, the counter advances by one per clock. When it is low, the counter holds. After its all-ones value it wraps to 0.
- R3: Control bit 0 (channel 0) and control bit 3 (channel 1) enable capture on a low-to-high transition of that channel's pin.
- R4: Control bit 1 (channel 0) and control bit 4 (channel 1) enable capture on a high-to-low transition of that channel's pin.
- R5: With both the rise and fall enables of a channel set, every transition of that pin loads its capture register.
- R6: A transition whose direction is not enabled leaves the capture register and the flag of that channel unchanged.
- R7: Control bit 2 (channel 0) and control bit 5 (channel 1) make a capture load set that channel's flag. With the bit clear, the load still happens but the flag stays as it was.
- R8: The status register (address 1) holds the channel 0 flag in bit 0 and the channel 1 flag in bit 1. Writing 1 to a bit clears that flag. If a load sets the flag in the same clock as the clear, the set wins. `irq` is the OR of both flags.
- R9: Control bits 31:6 are reserved. Writes to them are ignored and they read 0.
- R10: The first clock edge that samples the new pin level is edge k. The capture stores the counter value held just before edge k+2, so a capture in a wrapping cycle stores the value before the increment.
- R11: The compare register (address 3) is a full 32-bit read/write field that resets to 0.
- R12: The register map is: 0 control, 1 status, 2 counter, 3 compare, 4 capture 0, 5 capture 1. Unmapped addresses read 0. `bus_rdata` is registered and reflects the address presented in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Counter advance enable |
| cap_in | input | NCH | Asynchronous capture pins, one per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | OR of the channel flags |

## Verification
The bench builds the block with an 8-bit counter, two channels and a 32-bit bus. The narrow counter brings the wrap within a few hundred clocks. It also makes a capture in the wrapping cycle likely during ordinary stimulus. A behavioural model predicts the read data and `irq` on every clock. Directed sequences cover the exact capture latency, each edge-enable combination, the interrupt gating, flag clearing and the reserved control bits.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int BITS_PER_CH = 3;
  localparam int ADR_CTRL    = 0;
  localparam int ADR_STAT    = 1;
  localparam int ADR_COUNT   = 2;
  localparam int ADR_CMP     = 3;
  localparam int ADR_CAPBASE = 4;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } ch_ctrl_t;
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronised sample, sh[STAGES] the previous one
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cap_free_counter.sv
module cap_free_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             fall_i,
  input  ch_ctrl_t         ctl_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  logic             load;

  assign load = (rise_i & ctl_i.rise_en) | (fall_i & ctl_i.fall_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load) cap_q <= cnt_i;
      if (load && ctl_i.irq_en) flag_q <= 1'b1;
      else if (clr_i)           flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  // R6
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_i || fall_i) |=> $stable(cap_q));

  // R3
  rise_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i && ctl_i.rise_en) |=> cap_q == $past(cnt_i));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.irq_en && !flag_q) |=> !flag_q);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(rise_i || fall_i)) |=> !flag_q);
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top
  import cap_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic [NCH-1:0]    cap_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTRL_W = BITS_PER_CH * NCH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cmp_q;
  logic [CNT_W-1:0]  cnt;
  logic [NCH-1:0]    rise_v, fall_v, flag_v, clr_v;
  logic [CNT_W-1:0]  cap_v [NCH];
  logic [DATA_W-1:0] rd_next;
  logic              wr_ctrl, wr_stat, wr_cmp;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(ADR_STAT));
  assign wr_cmp  = bus_we && (bus_addr == ADDR_W'(ADR_CMP));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  cap_free_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(count_en), .cnt_o(cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_ctrl_t ctl;
    assign ctl      = ch_ctrl_t'(ctrl_q[BITS_PER_CH*c +: BITS_PER_CH]);
    assign clr_v[c] = wr_stat && bus_wdata[c];

    cap_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .pin_i(cap_in[c]),
      .rise_o(rise_v[c]), .fall_o(fall_v[c])
    );

    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .rise_i(rise_v[c]), .fall_i(fall_v[c]),
      .ctl_i(ctl), .clr_i(clr_v[c]), .cnt_i(cnt),
      .cap_o(cap_v[c]), .flag_o(flag_v[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL))  rd_next = DATA_W'(ctrl_q);
    if (bus_addr == ADDR_W'(ADR_STAT))  rd_next = DATA_W'(flag_v);
    if (bus_addr == ADDR_W'(ADR_COUNT)) rd_next = DATA_W'(cnt);
    if (bus_addr == ADDR_W'(ADR_CMP))   rd_next = cmp_q;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(ADR_CAPBASE + i)) rd_next = DATA_W'(cap_v[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq = |flag_v;

  // R9
  rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(ADR_CTRL) && !$past(rst)) |-> bus_rdata[DATA_W-1:CTRL_W] == '0);
endmodule

// File: tb/cap_timer_top_tb_top.sv
module cap_timer_top_tb_top;
  localparam int CW = 8;
  localparam int NC = 2;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          count_en = 1'b0;
  logic [NC-1:0] cap_in = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  cap_timer_top #(.CNT_W(CW), .NCH(NC), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .count_en(count_en), .cap_in(cap_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference
  bit [31:0] m_cnt, m_cmp, m_rdata;
  bit [5:0]  m_ctrl;
  bit [31:0] m_cap [NC];
  bit        m_flag [NC];
  bit        m_s1 [NC], m_s2 [NC], m_s3 [NC];
  bit        m_irq;
  bit [AW-1:0] m_last_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_rdata = 0;
      for (int c = 0; c < NC; c++) begin
        m_cap[c] = 0; m_flag[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
      end
    end else begin
      case (bus_addr)
        0: m_rdata = {26'd0, m_ctrl};
        1: m_rdata = {30'd0, m_flag[1], m_flag[0]};
        2: m_rdata = m_cnt;
        3: m_rdata = m_cmp;
        4: m_rdata = m_cap[0];
        5: m_rdata = m_cap[1];
        default: m_rdata = 0;
      endcase
      m_last_addr = bus_addr;
      for (int c = 0; c < NC; c++) begin
        bit r, f, ld, clr;
        r   = m_s2[c] && !m_s3[c];
        f   = !m_s2[c] && m_s3[c];
        ld  = (r && m_ctrl[3*c]) || (f && m_ctrl[3*c+1]);
        clr = bus_we && bus_addr == 1 && bus_wdata[c];
        if (ld) m_cap[c] = m_cnt;
        if (ld && m_ctrl[3*c+2]) m_flag[c] = 1;
        else if (clr)            m_flag[c] = 0;
        m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = cap_in[c];
      end
      if (bus_we && bus_addr == 0) m_ctrl = bus_wdata[5:0];
      if (bus_we && bus_addr == 3) m_cmp = bus_wdata;
      if (count_en) m_cnt = (m_cnt + 1) % (1 << CW);
    end
    m_irq = m_flag[0] || m_flag[1];
  end

  function automatic string tag_of(bit [AW-1:0] a);
    case (a)
      0: return "R9";
      1: return "R8";
      2: return "R2";
      3: return "R11";
      4, 5: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(tag_of(m_last_addr), bus_rdata, m_rdata);
      check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(bit [AW-1:0] a, bit [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(bit [AW-1:0] a, output bit [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      finished = 1;
      $finish;
    end
  end

  initial begin
    bit [31:0] v, c0, a, b;
    bit saw_wrap;
    idle(3);
    rst = 0;
    // R1: reset state with the counter held
    for (int i = 0; i < 6; i++) begin
      rd(i[AW-1:0], v);
      check("R1", v, 0);
    end
    check("R1 irq", {31'd0, irq}, 0);

    count_en = 1;
    // R9: reserved control bits dropped
    wr(0, 32'hFFFF_FFC9);
    rd(0, v);
    check("R9", v, 32'h09);

    // R10 and R3: exact latency of a rising capture on channel 0
    @(negedge clk);
    cap_in[0] = 1; bus_addr = 2;
    @(negedge clk);
    c0 = bus_rdata;
    idle(4);
    rd(4, v);
    check("R10 R3 cap0", v, (c0 + 2) % 256);
    check("R7 no flag without irq enable", {31'd0, irq}, 0);

    // R6: falling edge while only rising enabled
    rd(4, a);
    cap_in[0] = 0;
    idle(6);
    rd(4, b);
    check("R6 cap0 unchanged", b, a);
    rd(1, v);
    check("R6 flag unchanged", v, 0);

    // R4 and R7: falling capture with interrupt, rising ignored
    wr(0, 32'h06);
    cap_in[0] = 1;
    idle(6);
    rd(4, a);
    check("R6 rise ignored when only fall enabled", a, b);
    cap_in[0] = 0;
    idle(6);
    rd(4, b);
    check("R4 fall loads", {31'd0, b != a}, 1);
    rd(1, v);
    check("R7 flag set", v, 1);
    check("R8 irq high", {31'd0, irq}, 1);

    // R8: write-one-to-clear
    wr(1, 32'h1);
    rd(1, v);
    check("R8 cleared", v, 0);
    check("R8 irq low", {31'd0, irq}, 0);

    // R5: both edges on channel 1
    wr(0, 32'h38);
    cap_in[1] = 1;
    idle(6);
    rd(5, a);
    cap_in[1] = 0;
    idle(9);
    rd(5, b);
    check("R5 second edge reloads", {31'd0, b != a}, 1);
    rd(1, v);
    check("R5 flag ch1", v, 2);
    wr(1, 32'h2);

    // R11: compare register full width
    wr(3, 32'hDEAD_BEEF);
    rd(3, v);
    check("R11", v, 32'hDEAD_BEEF);

    // R12: unmapped address
    rd(15, v);
    check("R12", v, 0);

    // R2: hold then wrap
    count_en = 0;
    rd(2, a);
    idle(5);
    rd(2, b);
    check("R2 hold", b, a);
    count_en = 1;
    saw_wrap = 0;
    bus_addr = 2;
    a = bus_rdata;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (a == 255 && bus_rdata == 0) saw_wrap = 1;
      a = bus_rdata;
    end
    check("R2 wrap", {31'd0, saw_wrap}, 1);

    // mixed toggling, model compares every clock (captures across wrap)
    wr(0, 32'h3F);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i % 7 == 0) cap_in[0] = ~cap_in[0];
      if (i % 11 == 0) cap_in[1] = ~cap_in[1];
      if (i % 29 == 0) begin bus_we = 1; bus_addr = 1; bus_wdata = 3; end
      else begin bus_we = 0; bus_addr = AW'(i % 6); end
    end
    bus_we = 0;
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule